// File: doc/BRIEF.md
# Transactional Store Queue

This block holds every store a core issues inside a hardware transaction, so none of them reaches memory until the transaction commits. Each store brings an address, a data word and a byte-enable mask. The stores go into entries in arrival order. When the core commits, the queue writes the entries to a memory write port one at a time, oldest first. The port uses a valid/ready handshake. When the core aborts, the queue drops every held entry at once.

Loads from the core check the queue. Each byte takes its value from the youngest held store to the same address whose mask covers that byte. Every other byte comes from the cache data that the load supplies. The queue holds at most `DEPTH` stores, 32 by default. If a store arrives when the queue is full, the queue does not stall. It fails the transaction with the size cause and discards its contents.

Top module: `txn_store_queue`

## Requirements
- R1: No entry appears on the memory port (`mem_valid` low) while stores are being collected. The first write appears only in the cycle after a commit.
- R2: A store is taken when `st_valid` is high and `st_ready` is high. `st_ready` is high whenever no drain is running. A store presented in the same cycle as `commit` becomes the last entry drained.
- R3: After a commit, the entries leave in arrival order, one per cycle in which `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, the address, data and mask on the port hold steady.
- R4: `drain_done` is high for exactly one cycle after the last handshake, with `mem_valid` low and `st_ready` high again. It is also high for one cycle after a commit of an empty queue, and no write is issued in that case.
- R5: An abort while collecting clears all entries in one cycle. In the next cycle no load address hits, and a later commit issues no write.
- R6: A store that arrives while `DEPTH` entries are held is not kept. One cycle later `fail_valid` pulses for one cycle with `fail_cause` equal to 9'h040 (bit 6, the size cause). All entries are discarded. At all other times `fail_cause` is zero.
- R7: For each byte lane b (bits 8b+7:8b), `ld_data` holds the byte from the youngest held entry whose address equals `ld_addr` and whose mask bit b is set. If there is no such entry, it holds the lane of `ld_cache_data`. `ld_hit` is high when any held entry has the address. The path is combinational.
- R8: When `abort` is high together with `st_valid` and/or `commit`, the abort wins. The store is not kept and no drain starts.
- R9: During a drain, `st_ready` is low. Stores and aborts have no effect: every held entry is still written, and the rejected store never shows as a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Transactional store request |
| st_ready | output | 1 | Store can be accepted (no drain running) |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_mask | input | DATA_W/8 | Store byte enables |
| commit | input | 1 | Transaction commit pulse |
| abort | input | 1 | Transaction failure pulse |
| ld_addr | input | ADDR_W | Load address for forwarding |
| ld_cache_data | input | DATA_W | Data the cache returns for the load |
| ld_data | output | DATA_W | Load data merged with held stores |
| ld_hit | output | 1 | Some held entry matches ld_addr |
| mem_valid | output | 1 | Drain write available |
| mem_ready | input | 1 | Memory accepts the drain write |
| mem_addr | output | ADDR_W | Drain write address |
| mem_data | output | DATA_W | Drain write data |
| mem_mask | output | DATA_W/8 | Drain write byte enables |
| drain_done | output | 1 | Drain finished, queue empty |
| fail_valid | output | 1 | Transaction failure raised by the queue |
| fail_cause | output | 9 | Failure cause bits (bit 6 = size) |

## Verification
A wrong occupancy count shows on the ports quickly. It puts the wrong number of writes on the memory port at the next commit, or raises the size failure one store early or late, within a store or two. A stale valid bit left after an abort or a drain shows at once: a load to that address reports a hit in the next cycle. A read pointer that skips or repeats shows at the first handshake it touches, as an address or data out of arrival order. A wrong byte priority in forwarding shows in the same cycle, on the lane where an older store and a younger store overlap.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_DRAIN   = 1'b1
  } tsq_state_e;

  localparam int            CAUSE_W    = 9;
  localparam logic [CAUSE_W-1:0] CAUSE_SIZE = 9'h040;
endpackage

// File: rtl/tsq_ctrl.sv
module tsq_ctrl #(
  parameter int DEPTH = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  input  logic             commit,
  input  logic             abort,
  input  logic             mem_ready,
  output logic             st_ready,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             clr,
  output logic [IDX_W-1:0] rd_idx,
  output logic             mem_valid,
  output logic             drain_done,
  output logic             fail_valid
);
  import tsq_pkg::*;

  tsq_state_e       state_q, state_n;
  logic [CNT_W-1:0] count_q, count_n;
  logic [IDX_W-1:0] rd_q, rd_n;
  logic             done_q, done_n;
  logic             fail_q, fail_n;

  logic             collect, full, take, ovf, last;
  logic [CNT_W-1:0] cnt_after;

  always_comb begin
    collect   = (state_q == ST_COLLECT);
    full      = (count_q == CNT_W'(DEPTH));
    take      = collect && st_valid && !abort;
    wr_en     = take && !full;
    ovf       = take && full;
    last      = (CNT_W'(rd_q) + CNT_W'(1)) == count_q;
    cnt_after = count_q + CNT_W'(wr_en);

    state_n = state_q;
    count_n = count_q;
    rd_n    = rd_q;
    done_n  = 1'b0;
    fail_n  = 1'b0;
    clr     = 1'b0;

    if (collect) begin
      if (abort) begin
        count_n = '0;
        clr     = 1'b1;
      end else if (ovf) begin
        count_n = '0;
        fail_n  = 1'b1;
        clr     = 1'b1;
      end else begin
        count_n = cnt_after;
        if (commit) begin
          if (cnt_after == '0) begin
            done_n = 1'b1;
          end else begin
            state_n = ST_DRAIN;
            rd_n    = '0;
          end
        end
      end
    end else if (mem_ready) begin
      if (last) begin
        state_n = ST_COLLECT;
        count_n = '0;
        rd_n    = '0;
        done_n  = 1'b1;
        clr     = 1'b1;
      end else begin
        rd_n = rd_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      count_q <= '0;
      rd_q    <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      count_q <= count_n;
      rd_q    <= rd_n;
      done_q  <= done_n;
      fail_q  <= fail_n;
    end
  end

  assign st_ready   = collect;
  assign mem_valid  = !collect;
  assign wr_idx     = IDX_W'(count_q);
  assign rd_idx     = rd_q;
  assign drain_done = done_q;
  assign fail_valid = fail_q;
endmodule

// File: rtl/tsq_entries.sv
module tsq_entries #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [BYTES-1:0]             wr_mask,
  input  logic                         clr,
  output logic [DEPTH-1:0]             ent_valid,
  output logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  output logic [DEPTH-1:0][DATA_W-1:0] ent_data,
  output logic [DEPTH-1:0][BYTES-1:0]  ent_mask
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic              v_q;
    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;
    logic [BYTES-1:0]  m_q;
    logic              sel;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   v_q <= 1'b0;
      else if (clr) v_q <= 1'b0;
      else if (sel) v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        a_q <= wr_addr;
        d_q <= wr_data;
        m_q <= wr_mask;
      end
    end

    assign ent_valid[g] = v_q;
    assign ent_addr[g]  = a_q;
    assign ent_data[g]  = d_q;
    assign ent_mask[g]  = m_q;
  end
endmodule

// File: rtl/tsq_fwd.sv
module tsq_fwd #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8
) (
  input  logic [ADDR_W-1:0]            ld_addr,
  input  logic [DATA_W-1:0]            cache_data,
  input  logic [DEPTH-1:0]             ent_valid,
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0] ent_data,
  input  logic [DEPTH-1:0][BYTES-1:0]  ent_mask,
  output logic [DATA_W-1:0]            ld_data,
  output logic                         ld_hit
);
  // Index order equals arrival order, so later indices overwrite older ones.
  always_comb begin
    ld_data = cache_data;
    ld_hit  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_valid[i] && (ent_addr[i] == ld_addr)) begin
        ld_hit = 1'b1;
        for (int b = 0; b < BYTES; b++) begin
          if (ent_mask[i][b]) ld_data[b*8 +: 8] = ent_data[i][b*8 +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/txn_store_queue.sv
module txn_store_queue #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BYTES-1:0]  st_mask,
  input  logic              commit,
  input  logic              abort,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_cache_data,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_hit,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [BYTES-1:0]  mem_mask,
  output logic              drain_done,
  output logic              fail_valid,
  output logic [8:0]        fail_cause
);
  import tsq_pkg::*;

  logic                         wr_en, clr;
  logic [IDX_W-1:0]             wr_idx, rd_idx;
  logic [DEPTH-1:0]             ent_valid;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;
  logic [DEPTH-1:0][BYTES-1:0]  ent_mask;

  tsq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rst_n, .st_valid, .commit, .abort, .mem_ready,
    .st_ready, .wr_en, .wr_idx, .clr, .rd_idx, .mem_valid,
    .drain_done, .fail_valid
  );

  tsq_entries #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ent (
    .clk, .rst_n, .wr_en, .wr_idx,
    .wr_addr(st_addr), .wr_data(st_data), .wr_mask(st_mask), .clr,
    .ent_valid, .ent_addr, .ent_data, .ent_mask
  );

  tsq_fwd #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
    .ld_addr, .cache_data(ld_cache_data),
    .ent_valid, .ent_addr, .ent_data, .ent_mask,
    .ld_data, .ld_hit
  );

  assign mem_addr   = ent_addr[rd_idx];
  assign mem_data   = ent_data[rd_idx];
  assign mem_mask   = ent_mask[rd_idx];
  assign fail_cause = fail_valid ? CAUSE_SIZE : '0;
endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_ready,
  input logic              commit,
  input logic              abort,
  input logic              ld_hit,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic [BYTES-1:0]  mem_mask,
  input logic              drain_done,
  input logic              fail_valid,
  input logic [8:0]        fail_cause
);
  // R1
  no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(commit));

  // R3
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                && $stable(mem_data) && $stable(mem_mask));

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> st_ready && !mem_valid);

  // R5
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready && abort |=> !ld_hit);

  // R6
  size_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_valid |-> fail_cause == 9'h040);

  // R6
  fail_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_valid |=> !fail_valid);

  // R9
  no_store_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !st_ready);
endmodule

bind txn_store_queue tsq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .commit(commit),
  .abort(abort), .ld_hit(ld_hit), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
  .mem_mask(mem_mask), .drain_done(drain_done), .fail_valid(fail_valid),
  .fail_cause(fail_cause)
);

// File: tb/sim_txn_store_queue.sv
`timescale 1ns/1ps
module sim_txn_store_queue;
  localparam int D  = 4;
  localparam int AW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          st_valid, st_ready, commit, abort, ld_hit;
  logic [AW-1:0] st_addr, ld_addr, mem_addr;
  logic [DW-1:0] st_data, ld_cache_data, ld_data, mem_data;
  logic [1:0]    st_mask, mem_mask;
  logic          mem_valid, mem_ready, drain_done, fail_valid;
  logic [8:0]    fail_cause;

  always #2 clk = ~clk;

  txn_store_queue #(.DEPTH(D), .ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  logic [AW-1:0] ma [D];
  logic [DW-1:0] md [D];
  logic [1:0]    mm [D];
  int            mc = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Store at the current negedge; the design samples it at the next posedge.
  task automatic store(logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] m);
    st_valid = 1; st_addr = a; st_data = d; st_mask = m;
    check("R2", "st_ready while collecting", 32'(st_ready), 1);
    check("R1", "mem_valid while collecting", 32'(mem_valid), 0);
    if (mc < D) begin ma[mc] = a; md[mc] = d; mm[mc] = m; mc++; end
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic load_sweep(string req);
    for (int a = 0; a < 16; a++) begin
      logic [DW-1:0] exp_d;
      logic          exp_h;
      ld_addr = AW'(a);
      ld_cache_data = 16'h5A00 ^ 16'(a * 16'h1111);
      exp_d = ld_cache_data;
      exp_h = 0;
      for (int i = 0; i < mc; i++) begin
        if (ma[i] == AW'(a)) begin
          exp_h = 1;
          for (int b = 0; b < 2; b++)
            if (mm[i][b]) exp_d[b*8 +: 8] = md[i][b*8 +: 8];
        end
      end
      #0.5;
      check(req, "ld_hit", 32'(ld_hit), 32'(exp_h));
      check(req, "ld_data", 32'(ld_data), 32'(exp_d));
    end
  endtask

  task automatic commit_pulse();
    commit = 1;
    @(negedge clk);
    commit = 0;
  endtask

  // Called at the negedge after the commit edge.
  task automatic drain_loop(int stall_seed);
    int k = 0;
    int cyc = 0;
    while (k < mc && cyc < 100) begin
      check("R3", "mem_valid in drain", 32'(mem_valid), 1);
      check("R3", "mem_addr order", 32'(mem_addr), 32'(ma[k]));
      check("R3", "mem_data order", 32'(mem_data), 32'(md[k]));
      check("R3", "mem_mask order", 32'(mem_mask), 32'(mm[k]));
      check("R4", "drain_done early", 32'(drain_done), 0);
      mem_ready = ((cyc + stall_seed) % 3) != 1;
      @(negedge clk);
      if (mem_ready) k++;
      cyc++;
    end
    mem_ready = 0;
    check("R4", "drain_done after last", 32'(drain_done), 1);
    check("R4", "mem_valid after last", 32'(mem_valid), 0);
    check("R4", "st_ready after last", 32'(st_ready), 1);
    mc = 0;
    @(negedge clk);
    check("R4", "drain_done one cycle", 32'(drain_done), 0);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; st_valid = 0; commit = 0; abort = 0; mem_ready = 0;
    st_addr = '0; st_data = '0; st_mask = '0; ld_addr = '0; ld_cache_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R2", "reset st_ready", 32'(st_ready), 1);
    check("R1", "reset mem_valid", 32'(mem_valid), 0);
    check("R4", "reset drain_done", 32'(drain_done), 0);
    check("R6", "reset fail_valid", 32'(fail_valid), 0);
    check("R6", "reset fail_cause", 32'(fail_cause), 0);
    load_sweep("R7");

    // Sweep of fill levels, with overlapping addresses and masks (R7, R3, R4)
    for (int n = 0; n <= D; n++) begin
      for (int i = 0; i < n; i++)
        store(AW'((i >> 1) + (n % 2)), 16'(n * 16'h1111 + i * 16'h0203 + 16'h0101),
              2'((i + n) % 3 + 1));
      load_sweep("R7");
      commit_pulse();
      drain_loop(n);
      load_sweep("R7");
    end

    // R5: abort discards everything in one cycle
    store(4'h2, 16'hBEEF, 2'b11);
    store(4'h3, 16'hCAFE, 2'b01);
    store(4'h2, 16'h1234, 2'b10);
    abort = 1;
    @(negedge clk);
    abort = 0;
    mc = 0;
    load_sweep("R5");
    commit_pulse();
    drain_loop(0);

    // R8: abort wins over store and commit in the same cycle
    store(4'h7, 16'h7777, 2'b11);
    store(4'h8, 16'h8888, 2'b11);
    abort = 1; commit = 1; st_valid = 1; st_addr = 4'h9; st_data = 16'h9999; st_mask = 2'b11;
    @(negedge clk);
    abort = 0; commit = 0; st_valid = 0;
    mc = 0;
    check("R8", "no drain after abort+commit", 32'(mem_valid), 0);
    check("R8", "no done after abort+commit", 32'(drain_done), 0);
    load_sweep("R8");
    commit_pulse();
    drain_loop(1);

    // R6: overflow raises size cause and discards
    for (int i = 0; i < D; i++) store(AW'(i + 10), 16'(16'hA0A0 + i), 2'b11);
    st_valid = 1; st_addr = 4'hF; st_data = 16'hFFFF; st_mask = 2'b11;
    @(negedge clk);
    st_valid = 0;
    mc = 0;
    check("R6", "fail_valid on overflow", 32'(fail_valid), 1);
    check("R6", "fail_cause size bit", 32'(fail_cause), 32'h040);
    load_sweep("R6");
    @(negedge clk);
    check("R6", "fail_valid one cycle", 32'(fail_valid), 0);
    check("R6", "fail_cause idle", 32'(fail_cause), 0);
    commit_pulse();
    drain_loop(2);

    // R2: store in the commit cycle is drained last
    store(4'h4, 16'h4141, 2'b01);
    store(4'h5, 16'h5252, 2'b10);
    st_valid = 1; commit = 1; st_addr = 4'h4; st_data = 16'h6363; st_mask = 2'b11;
    ma[mc] = 4'h4; md[mc] = 16'h6363; mm[mc] = 2'b11; mc++;
    @(negedge clk);
    st_valid = 0; commit = 0;
    drain_loop(0);

    // R9: stores and aborts during a drain have no effect
    store(4'h1, 16'h1111, 2'b11);
    store(4'h6, 16'h6666, 2'b01);
    store(4'h1, 16'h2222, 2'b10);
    commit_pulse();
    st_valid = 1; abort = 1; st_addr = 4'hE; st_data = 16'hEEEE; st_mask = 2'b11;
    mem_ready = 0;
    check("R9", "st_ready low in drain", 32'(st_ready), 0);
    @(negedge clk);
    st_valid = 0; abort = 0;
    check("R9", "drain survives abort", 32'(mem_valid), 1);
    drain_loop(2);
    ld_addr = 4'hE;
    #0.5;
    check("R9", "rejected store not held", 32'(ld_hit), 0);

    finish_run();
  end
endmodule